// File: doc/BRIEF.md
# Stall and Interrupt Test Coprocessor

This block is a verification-support coprocessor for a processor core. It has a bank of sixteen data registers and two request ports that share one request channel. Either port can put a value into a register or get one back. The first port can also move words between memory and a register as a block transfer, in a short form or in a long multi-beat form. A fourth request kind carries a command. Commands can stall the requester for a number of cycles held in a register, or schedule an active-low fast or normal interrupt after a register-held delay. Other commands release those interrupts or capture a free-running cycle count into a register.

The core presents one request per cycle: valid, port, kind, the 32-bit instruction word and write data. The block answers in the same cycle with exactly one strobe. Done ends the request. Busy asks the requester to present the request again next cycle. Refuse means the request is not supported. Stall commands and long block transfers answer busy for several cycles before they answer done. The interrupt lines are registered outputs that feed the core's interrupt inputs.

Top module: `stallirq_copro`

## Requirements
- R1: Reset clears every register, the cycle counter and all pending interrupt delays. Both interrupt lines are high and no response strobe is active while no request is valid.
- R2: A put request (kind 0) on either port writes the write data into the register selected by instruction bits 19:16 and answers done. A get request (kind 1) answers done with that register's value on the read data port in the same cycle.
- R3: On port 0, a load (kind 2) writes the write data into the register selected by instruction bits 15:12, and a store (kind 3) returns that register's value. With instruction bit 22 clear, either one answers done in its first cycle.
- R4: With instruction bit 22 set, a load or store on port 0 takes LONG_BEATS consecutive request cycles. It answers busy on every beat but the last and done on the last. Every beat writes or reads the selected register.
- R5: Command 0 (kind 4, bits 23:20 = 0) is accepted on either port. It takes N from the register selected by bits 3:0. N = 0 answers done at once. Otherwise the block answers busy for N request cycles, then done, as long as the request is held. If the request is dropped, the stall is abandoned.
- R6: The cycle counter is DATA_W bits wide, free-running and wraps. A stall with N below 2^(DATA_W-1) keeps its length when it spans the wrap.
- R7: Commands 1 and 2 on port 1 drive the fast (fiqN) or normal (irqN) line low N clock edges after the edge that accepts the command. With N = 0 the line goes low at the accepting edge. A new schedule replaces any pending delay on that line.
- R8: Commands 3 and 4 on port 1 drive fiqN or irqN high at the accepting edge and cancel any pending delay on that line.
- R9: Command 5 on port 1 writes the cycle count of the accepting cycle into the register selected by bits 3:0.
- R10: The block answers refuse to all of these, and a refused request changes no register and no line:
  - a command with an opcode other than 0 on port 0;
  - a command with an opcode above 5 on port 1;
  - a load or store on port 1;
  - kinds 5 to 7.
- R11: Each cycle asserts at most one of done, busy and refuse, and none of them without a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqPort | input | 1 | 0 = first port, 1 = second port |
| reqKind | input | 3 | 0 put, 1 get, 2 load, 3 store, 4 command |
| reqInstr | input | 32 | Instruction word carrying register selects and opcode |
| reqWdata | input | DATA_W | Data for put and load |
| rspDone | output | 1 | Request complete |
| rspBusy | output | 1 | Request must be presented again |
| rspRefuse | output | 1 | Request not supported |
| rspRdata | output | DATA_W | Data for get and store |
| fiqN | output | 1 | Active-low fast interrupt |
| irqN | output | 1 | Active-low normal interrupt |

## Verification
The bench builds the block with DATA_W = 16 and LONG_BEATS = 3. The 16-bit counter wraps after 65536 cycles, so a 20-cycle stall can be started just before the wrap and timed across it. The same width lets a cycle-count capture be checked on both sides of the wrap. Three beats put a middle busy beat into every long transfer, which shows that the beat counter advances correctly and not just from first beat to last.

// File: rtl/stallirq_pkg.sv
package stallirq_pkg;
  // request kinds
  localparam logic [2:0] KIND_PUT   = 3'd0;
  localparam logic [2:0] KIND_GET   = 3'd1;
  localparam logic [2:0] KIND_LOAD  = 3'd2;
  localparam logic [2:0] KIND_STORE = 3'd3;
  localparam logic [2:0] KIND_CMD   = 3'd4;

  // command opcodes (instruction bits 23:20)
  localparam logic [3:0] OP_STALL   = 4'd0;
  localparam logic [3:0] OP_FIQ     = 4'd1;
  localparam logic [3:0] OP_IRQ     = 4'd2;
  localparam logic [3:0] OP_FIQ_REL = 4'd3;
  localparam logic [3:0] OP_IRQ_REL = 4'd4;
  localparam logic [3:0] OP_STAMP   = 4'd5;

  localparam int SEL_W     = 4;
  localparam int NUM_LINES = 2;  // 0 = fast, 1 = normal

  typedef struct packed {
    logic                 wrEn;
    logic                 wrStamp;
    logic [SEL_W-1:0]     wrIdx;
    logic                 rdEn;
    logic [SEL_W-1:0]     rdIdx;
    logic [SEL_W-1:0]     opIdx;
    logic [NUM_LINES-1:0] sched;
    logic [NUM_LINES-1:0] rel;
  } ctrlStrobe_t;
endpackage

// File: rtl/stallirq_ctrl.sv
module stallirq_ctrl
  import stallirq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LONG_BEATS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPort,
  input  logic [2:0]        reqKind,
  input  logic [31:0]       reqInstr,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] cycleCnt,
  output ctrlStrobe_t       stb,
  output logic              rspDone,
  output logic              rspBusy,
  output logic              rspRefuse
);
  localparam int BEAT_W = $clog2(LONG_BEATS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LONG_BEATS - 1);

  logic              stallActive, stallNext;
  logic [DATA_W-1:0] stallEnd, endNext;
  logic [BEAT_W-1:0] beatCnt, beatNext;
  logic [DATA_W-1:0] stallDiff;
  logic [3:0]        opcode;
  logic              cmdLegal;
  logic              unusedInstr;

  assign opcode      = reqInstr[23:20];
  assign stallDiff   = cycleCnt - stallEnd;
  assign cmdLegal    = reqPort ? (opcode <= OP_STAMP) : (opcode == OP_STALL);
  assign unusedInstr = ^{reqInstr[31:24], reqInstr[11:4]};

  always_comb begin
    stb       = '0;
    stb.opIdx = reqInstr[3:0];
    rspDone   = 1'b0;
    rspBusy   = 1'b0;
    rspRefuse = 1'b0;
    stallNext = stallActive;
    endNext   = stallEnd;
    beatNext  = '0;
    if (!reqValid) begin
      stallNext = 1'b0;
    end else if (stallActive) begin
      // wrap-safe: reached when the difference is non-negative
      if (!stallDiff[DATA_W-1]) begin
        rspDone   = 1'b1;
        stallNext = 1'b0;
      end else begin
        rspBusy = 1'b1;
      end
    end else begin
      case (reqKind)
        KIND_PUT: begin
          rspDone   = 1'b1;
          stb.wrEn  = 1'b1;
          stb.wrIdx = reqInstr[19:16];
        end
        KIND_GET: begin
          rspDone   = 1'b1;
          stb.rdEn  = 1'b1;
          stb.rdIdx = reqInstr[19:16];
        end
        KIND_LOAD, KIND_STORE: begin
          if (reqPort) begin
            rspRefuse = 1'b1;
          end else begin
            if (reqKind == KIND_LOAD) begin
              stb.wrEn  = 1'b1;
              stb.wrIdx = reqInstr[15:12];
            end else begin
              stb.rdEn  = 1'b1;
              stb.rdIdx = reqInstr[15:12];
            end
            if (reqInstr[22] && (beatCnt != LAST_BEAT)) begin
              rspBusy  = 1'b1;
              beatNext = beatCnt + 1'b1;
            end else begin
              rspDone = 1'b1;
            end
          end
        end
        KIND_CMD: begin
          if (!cmdLegal) begin
            rspRefuse = 1'b1;
          end else begin
            case (opcode)
              OP_STALL: begin
                if (operand == '0) begin
                  rspDone = 1'b1;
                end else begin
                  rspBusy   = 1'b1;
                  stallNext = 1'b1;
                  endNext   = cycleCnt + operand;
                end
              end
              OP_FIQ:     begin rspDone = 1'b1; stb.sched[0] = 1'b1; end
              OP_IRQ:     begin rspDone = 1'b1; stb.sched[1] = 1'b1; end
              OP_FIQ_REL: begin rspDone = 1'b1; stb.rel[0]   = 1'b1; end
              OP_IRQ_REL: begin rspDone = 1'b1; stb.rel[1]   = 1'b1; end
              default: begin
                rspDone     = 1'b1;
                stb.wrEn    = 1'b1;
                stb.wrStamp = 1'b1;
                stb.wrIdx   = reqInstr[3:0];
              end
            endcase
          end
        end
        default: rspRefuse = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallActive <= 1'b0;
      stallEnd    <= '0;
      beatCnt     <= '0;
    end else begin
      stallActive <= stallNext;
      stallEnd    <= endNext;
      beatCnt     <= beatNext;
    end
  end
endmodule

// File: rtl/stallirq_dp.sv
module stallirq_dp
  import stallirq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] cycleCnt,
  output logic [DATA_W-1:0] rdData,
  output logic              fiqN,
  output logic              irqN
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic [DATA_W-1:0]    regFile [REG_COUNT];
  logic [NUM_LINES-1:0] lineLow;

  assign operand = regFile[stb.opIdx[IDX_W-1:0]];
  assign rdData  = stb.rdEn ? regFile[stb.rdIdx[IDX_W-1:0]] : '0;
  assign fiqN    = ~lineLow[0];
  assign irqN    = ~lineLow[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
      if (stb.wrEn)
        regFile[stb.wrIdx[IDX_W-1:0]] <= stb.wrStamp ? cycleCnt : wrData;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [DATA_W-1:0] delayCnt;
    logic              pending;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        delayCnt   <= '0;
        pending    <= 1'b0;
        lineLow[g] <= 1'b0;
      end else if (stb.sched[g]) begin
        if (operand == '0) begin
          lineLow[g] <= 1'b1;
          pending    <= 1'b0;
        end else begin
          delayCnt <= operand;
          pending  <= 1'b1;
        end
      end else if (stb.rel[g]) begin
        lineLow[g] <= 1'b0;
        pending    <= 1'b0;
      end else if (pending) begin
        if (delayCnt == DATA_W'(1)) begin
          lineLow[g] <= 1'b1;
          pending    <= 1'b0;
        end else begin
          delayCnt <= delayCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stallirq_copro.sv
module stallirq_copro
  import stallirq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LONG_BEATS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPort,
  input  logic [2:0]        reqKind,
  input  logic [31:0]       reqInstr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspBusy,
  output logic              rspRefuse,
  output logic [DATA_W-1:0] rspRdata,
  output logic              fiqN,
  output logic              irqN
);
  ctrlStrobe_t       stb;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] cycleCnt;

  stallirq_ctrl #(.DATA_W(DATA_W), .LONG_BEATS(LONG_BEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqKind(reqKind), .reqInstr(reqInstr), .operand(operand),
    .cycleCnt(cycleCnt), .stb(stb), .rspDone(rspDone),
    .rspBusy(rspBusy), .rspRefuse(rspRefuse)
  );

  stallirq_dp #(.DATA_W(DATA_W), .REG_COUNT(16)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(reqWdata),
    .operand(operand), .cycleCnt(cycleCnt), .rdData(rspRdata),
    .fiqN(fiqN), .irqN(irqN)
  );
endmodule

// File: rtl/stallirq_chk.sv
module stallirq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqPort,
  input logic [2:0] reqKind,
  input logic [3:0] reqOp,
  input logic       rspDone,
  input logic       rspBusy,
  input logic       rspRefuse,
  input logic       fiqN,
  input logic       irqN
);
  // R1
  reset_lines_high_chk: assert property (@(posedge clk) !rstN |-> (fiqN && irqN));

  // R11
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspDone, rspBusy, rspRefuse}));

  // R11
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(rspDone || rspBusy || rspRefuse));

  // R10
  refuse_high_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPort && reqKind == 3'd4 && reqOp > 4'd5 && !$past(rspBusy))
      |-> rspRefuse);

  // R8
  fast_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPort && reqKind == 3'd4 && reqOp == 4'd3 && !$past(rspBusy))
      |=> fiqN);

  // R8
  normal_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPort && reqKind == 3'd4 && reqOp == 4'd4 && !$past(rspBusy))
      |=> irqN);
endmodule

bind stallirq_copro stallirq_chk uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
  .reqKind(reqKind), .reqOp(reqInstr[23:20]), .rspDone(rspDone),
  .rspBusy(rspBusy), .rspRefuse(rspRefuse), .fiqN(fiqN), .irqN(irqN)
);

// File: tb/tb_stallirq_copro.sv
module tb_stallirq_copro;
  localparam int DW = 16;
  localparam int LB = 3;
  localparam logic [2:0] R_DONE = 3'b001, R_BUSY = 3'b010, R_REF = 3'b100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqPort = 1'b0;
  logic [2:0]    reqKind = 3'd0;
  logic [31:0]   reqInstr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspDone, rspBusy, rspRefuse, fiqN, irqN;
  logic [DW-1:0] rspRdata;

  always #10 clk = ~clk;

  stallirq_copro #(.DATA_W(DW), .LONG_BEATS(LB)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqKind(reqKind), .reqInstr(reqInstr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspBusy(rspBusy), .rspRefuse(rspRefuse),
    .rspRdata(rspRdata), .fiqN(fiqN), .irqN(irqN)
  );

  typedef struct {
    logic [2:0]    resp;
    bit            chkData;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int failures = 0;
  logic [DW-1:0] cyc;

  // spec model of the free-running counter
  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= '0; else cyc <= cyc + 1'b1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(logic [3:0] op, logic [3:0] rn, logic [3:0] rd, logic [3:0] rm);
    return {8'h00, op, rn, rd, 8'h00, rm};
  endfunction

  task automatic beat(logic port, logic [2:0] kind, logic [31:0] instr, logic [DW-1:0] wd,
                      logic [2:0] resp, bit cd, logic [DW-1:0] ed, string tag);
    exp_t e;
    e.resp = resp; e.chkData = cd; e.data = ed; e.tag = tag;
    expQ.push_back(e);
    reqValid = 1'b1; reqPort = port; reqKind = kind; reqInstr = instr; reqWdata = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = 1'b0; reqKind = 3'd0; reqInstr = '0; reqWdata = '0;
  endtask

  task automatic put(logic port, logic [3:0] idx, logic [DW-1:0] v, string tag);
    beat(port, 3'd0, ins(4'd0, idx, 4'd0, 4'd0), v, R_DONE, 0, '0, tag);
  endtask

  task automatic get(logic port, logic [3:0] idx, logic [DW-1:0] v, string tag);
    beat(port, 3'd1, ins(4'd0, idx, 4'd0, 4'd0), '0, R_DONE, 1, v, tag);
  endtask

  task automatic stallRun(logic port, logic [3:0] rm, int n, string tag);
    for (int i = 0; i < n; i++) beat(port, 3'd4, ins(4'd0, 4'd0, 4'd0, rm), '0, R_BUSY, 0, '0, tag);
    beat(port, 3'd4, ins(4'd0, 4'd0, 4'd0, rm), '0, R_DONE, 0, '0, tag);
    idle();
  endtask

  // called at the negedge right after the accepting edge
  task automatic watchLine(bit fast, int n, string tag);
    for (int j = 0; j <= n + 1; j++) begin
      if (j > 0) @(negedge clk);
      #1;
      check((fast ? fiqN : irqN) == (j >= n ? 1'b0 : 1'b1), tag,
            32'(fast ? fiqN : irqN), 32'(j >= n ? 0 : 1));
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #5;
    if (reqValid) begin
      if (expQ.size() == 0) begin
        check(0, "R11 unexpected request", 0, 1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check({rspRefuse, rspBusy, rspDone} == e.resp, e.tag,
              32'({rspRefuse, rspBusy, rspDone}), 32'(e.resp));
        if (e.chkData) check(rspRdata == e.data, e.tag, 32'(rspRdata), 32'(e.data));
      end
    end else if (rstN) begin
      check(!(rspDone || rspBusy || rspRefuse), "R11 strobe while idle",
            32'({rspRefuse, rspBusy, rspDone}), 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R11 act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] stampExp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fiqN && irqN, "R1 lines in reset", 32'({fiqN, irqN}), 32'h3);
    check(!(rspDone || rspBusy || rspRefuse), "R1 strobes in reset",
          32'({rspRefuse, rspBusy, rspDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    get(0, 4'd7, '0, "R1 reg cleared");

    // R2 put / get on both ports
    put(0, 4'd3, 16'hA5A5, "R2 put p0");
    get(1, 4'd3, 16'hA5A5, "R2 get p1");
    put(1, 4'd12, 16'h0F0F, "R2 put p1");
    get(0, 4'd12, 16'h0F0F, "R2 get p0");

    // R3 short block transfer
    beat(0, 3'd2, ins(4'd0, 4'd0, 4'd5, 4'd0), 16'h1234, R_DONE, 0, '0, "R3 short load");
    beat(0, 3'd3, ins(4'd0, 4'd0, 4'd5, 4'd0), '0, R_DONE, 1, 16'h1234, "R3 short store");
    get(1, 4'd5, 16'h1234, "R3 readback");

    // R4 long block transfer (bit 22 set)
    beat(0, 3'd2, ins(4'd4, 4'd0, 4'd8, 4'd0), 16'h1111, R_BUSY, 0, '0, "R4 long load b0");
    beat(0, 3'd2, ins(4'd4, 4'd0, 4'd8, 4'd0), 16'h2222, R_BUSY, 0, '0, "R4 long load b1");
    beat(0, 3'd2, ins(4'd4, 4'd0, 4'd8, 4'd0), 16'h3333, R_DONE, 0, '0, "R4 long load b2");
    get(1, 4'd8, 16'h3333, "R4 last beat kept");
    for (int b = 0; b < LB; b++)
      beat(0, 3'd3, ins(4'd4, 4'd0, 4'd8, 4'd0), '0, (b == LB - 1) ? R_DONE : R_BUSY,
           1, 16'h3333, "R4 long store");
    idle();

    // R10 refusals leave state untouched
    beat(0, 3'd4, ins(4'd1, 4'd0, 4'd0, 4'd0), '0, R_REF, 0, '0, "R10 p0 op1");
    beat(1, 3'd4, ins(4'd6, 4'd0, 4'd0, 4'd0), '0, R_REF, 0, '0, "R10 p1 op6");
    beat(1, 3'd2, ins(4'd0, 4'd0, 4'd9, 4'd0), 16'hBEEF, R_REF, 0, '0, "R10 p1 load");
    beat(0, 3'd5, ins(4'd0, 4'd9, 4'd0, 4'd0), 16'hBEEF, R_REF, 0, '0, "R10 kind5");
    get(0, 4'd9, '0, "R10 reg unchanged");
    idle();
    #1;
    check(fiqN == 1'b1, "R10 fast line unchanged", 32'(fiqN), 1);

    // R5 stall
    @(negedge clk);
    put(0, 4'd1, 16'd7, "R5 set N");
    stallRun(0, 4'd1, 7, "R5 stall 7 p0");
    stallRun(1, 4'd0, 0, "R5 stall 0 p1");
    put(0, 4'd11, 16'd5, "R5 set N");
    beat(0, 3'd4, ins(4'd0, 4'd0, 4'd0, 4'd11), '0, R_BUSY, 0, '0, "R5 abandon");
    beat(0, 3'd4, ins(4'd0, 4'd0, 4'd0, 4'd11), '0, R_BUSY, 0, '0, "R5 abandon");
    idle();
    @(negedge clk);
    put(0, 4'd13, 16'd77, "R5 after abandon");
    get(1, 4'd13, 16'd77, "R5 after abandon");

    // R9 capture
    stampExp = cyc;
    beat(1, 3'd4, ins(4'd5, 4'd0, 4'd0, 4'd14), '0, R_DONE, 0, '0, "R9 stamp");
    get(0, 4'd14, stampExp, "R9 stamp value");
    idle();

    // R7 fast after 4, normal immediate
    @(negedge clk);
    put(0, 4'd6, 16'd4, "R7 set N");
    beat(1, 3'd4, ins(4'd1, 4'd0, 4'd0, 4'd6), '0, R_DONE, 0, '0, "R7 fast sched");
    idle();
    watchLine(1, 4, "R7 fast delay 4");
    @(negedge clk);
    beat(1, 3'd4, ins(4'd2, 4'd0, 4'd0, 4'd0), '0, R_DONE, 0, '0, "R7 normal N=0");
    idle();
    watchLine(0, 0, "R7 normal immediate");

    // R8 release both
    @(negedge clk);
    beat(1, 3'd4, ins(4'd3, 4'd0, 4'd0, 4'd0), '0, R_DONE, 0, '0, "R8 fast release");
    beat(1, 3'd4, ins(4'd4, 4'd0, 4'd0, 4'd0), '0, R_DONE, 0, '0, "R8 normal release");
    idle();
    #1;
    check(fiqN && irqN, "R8 both high", 32'({fiqN, irqN}), 32'h3);

    // R7 reschedule replaces pending delay
    @(negedge clk);
    put(0, 4'd2, 16'd10, "R7 set N");
    put(0, 4'd4, 16'd4, "R7 set N");
    beat(1, 3'd4, ins(4'd2, 4'd0, 4'd0, 4'd2), '0, R_DONE, 0, '0, "R7 sched 10");
    idle();
    repeat (3) @(negedge clk);
    beat(1, 3'd4, ins(4'd2, 4'd0, 4'd0, 4'd4), '0, R_DONE, 0, '0, "R7 resched 4");
    idle();
    watchLine(0, 4, "R7 resched delay");

    // R8 release cancels a pending delay
    @(negedge clk);
    put(0, 4'd10, 16'd6, "R8 set N");
    beat(1, 3'd4, ins(4'd1, 4'd0, 4'd0, 4'd10), '0, R_DONE, 0, '0, "R8 sched 6");
    idle();
    repeat (2) @(negedge clk);
    beat(1, 3'd4, ins(4'd3, 4'd0, 4'd0, 4'd0), '0, R_DONE, 0, '0, "R8 cancel");
    idle();
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      #1;
      check(fiqN == 1'b1, "R8 pending cancelled", 32'(fiqN), 1);
    end

    // R6 stall across counter wrap
    @(negedge clk);
    put(0, 4'd1, 16'd20, "R6 set N");
    idle();
    while (cyc != 16'hFFF8) @(negedge clk);
    stallRun(0, 4'd1, 20, "R6 stall across wrap");
    stampExp = cyc;
    beat(1, 3'd4, ins(4'd5, 4'd0, 4'd0, 4'd15), '0, R_DONE, 0, '0, "R6 stamp after wrap");
    get(0, 4'd15, stampExp, "R6 stamp after wrap");
    idle();

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule